// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

The block is a watchdog counter for a system controller. Software selects one of eight timeout periods and enables the watchdog through a small control write port. It then strobes a restart input often enough to keep the counter from reaching the selected limit. If the limit is reached while the watchdog is enabled, the block drives a system reset request for a fixed number of cycles. When the request is released, counting starts again from zero.

Alongside the counter, the block keeps a five-bit register of sticky cause flags. The flags record whether the last reset came from power-on, the external reset pin, the brown-out detector, the watchdog itself or a debug-port reset request. The voltage detectors, the pin filter and the debug port lie outside the block. Each reaches it as a synchronous digital request line. The watchdog clock is the block clock, qualified by a tick enable.

The watchdog can be enabled by any control write. Turning it off, or changing the period, needs a two-step unlock sequence. This makes it hard for runaway code to silence the watchdog by accident.

Top module: `wdt_reset_unit`

## Requirements
- R1: After reset the cause flags read 5'b00001 (bit 0 = power-on), the watchdog is disabled with period field 0, and no reset request is driven.
- R2: With the watchdog enabled and period field n, the reset request rises on the cycle after the 2^(BASE_EXP+n)-th qualified tick counted since the last clear. A tick is qualified when `tick` is high. Counting starts on the cycle after enable takes effect.
- R3: A restart strobe clears the count to zero, and a cycle with `tick` low does not advance it. Restarting at least once per period keeps the request low.
- R4: Once raised by a timeout, the reset request stays high for exactly 16 cycles. Restart strobes during that time have no effect. Counting resumes from zero after release.
- R5: A control write with the enable bit at 1 always enables the watchdog. A write with the unlock bit at 1 opens a window for the next 4 cycles and changes no period. Only a write with the unlock bit at 0 inside that window may clear enable or load a new period, and it closes the window. Any other write changes neither.
- R6: A watchdog timeout sets flag bit 3.
- R7: A high on the external, brown-out or debug request sets flag bit 1, 2 or 4 respectively, and clears the watchdog count.
- R8: A high on the power-on request sets the flags to 5'b00001, disables the watchdog, sets the period field to 0 and ends a reset request in progress.
- R9: A flag write clears each flag whose keep bit is 0 and leaves the flags whose keep bit is 1 unchanged. A source setting a flag in the same cycle wins over the clear. Without a write, set flags stay set.
- R10: While the watchdog is disabled it never raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Watchdog count enable |
| kick | input | 1 | Restart strobe |
| ctl_wr | input | 1 | Control write strobe |
| ctl_unlock | input | 1 | Unlock bit of the control write |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_period | input | 3 | Period field of the control write |
| flag_wr | input | 1 | Flag write strobe |
| flag_keep | input | 5 | Per-flag keep mask of the flag write |
| por_req | input | 1 | Power-on reset request |
| ext_req | input | 1 | External pin reset request |
| bod_req | input | 1 | Brown-out reset request |
| dbg_req | input | 1 | Debug-port reset request |
| sys_rst_req | output | 1 | System reset request from watchdog timeout |
| cause_flags | output | 5 | Sticky cause flags: 0 power-on, 1 external, 2 brown-out, 3 watchdog, 4 debug |
| cfg_en | output | 1 | Current watchdog enable |
| cfg_period | output | 3 | Current period field |

## Verification
The assertions assume that every input changes only between rising clock edges and is already synchronous to `clk`. They also assume that the source request lines are plain levels, which may last one cycle or many. They make no assumption about the pattern of `tick`, or about writes and restarts arriving in the same cycle as a timeout. The stimulus drives all inputs on the falling edge. It mixes directed sequences (locked and unlocked writes, late writes, hold-time restarts, power-on during a hold) with a long pseudo-random run over all inputs at low rates. That run reaches timeouts, overlapping source requests and collisions between writes and sets.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;

  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned PER_W   = 3;

  localparam int unsigned IDX_POR = 0;
  localparam int unsigned IDX_EXT = 1;
  localparam int unsigned IDX_BOD = 2;
  localparam int unsigned IDX_WDT = 3;
  localparam int unsigned IDX_DBG = 4;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } wd_state_e;

endpackage

// File: rtl/wdt_ctl.sv
module wdt_ctl
  import wdt_rst_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             por,
  input  logic             wr,
  input  logic             unlock,
  input  logic             en_in,
  input  logic [PER_W-1:0] per_in,
  output logic             en_o,
  output logic [PER_W-1:0] per_o
);

  localparam int unsigned WW = $clog2(WIN_CYC + 1);

  logic             en_q, en_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [WW-1:0]    win_q, win_d;
  logic             win_open;

  assign win_open = (win_q != '0);

  always_comb begin
    en_d  = en_q;
    per_d = per_q;
    win_d = win_q;
    if (por) begin
      en_d  = 1'b0;
      per_d = '0;
      win_d = '0;
    end else if (wr) begin
      if (unlock) begin
        win_d = WW'(WIN_CYC);
        en_d  = en_q | en_in;
      end else if (win_open) begin
        en_d  = en_in;
        per_d = per_in;
        win_d = '0;
      end else begin
        en_d  = en_q | en_in;
      end
    end else if (win_open) begin
      win_d = win_q - WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q  <= 1'b0;
      per_q <= '0;
      win_q <= '0;
    end else begin
      en_q  <= en_d;
      per_q <= per_d;
      win_q <= win_d;
    end
  end

  assign en_o  = en_q;
  assign per_o = per_q;

  // R5: with the window closed the period cannot move
  assert_locked_period_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!win_open && !por) |=> $stable(per_q));

  // R5: with the window closed an enabled watchdog stays enabled
  assert_locked_enable_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (en_q && !win_open && !por) |=> en_q);

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_rst_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             por,
  input  logic             src_clr,
  input  logic             kick,
  input  logic             tick,
  input  logic             en,
  input  logic [PER_W-1:0] per,
  output logic             hold_o,
  output logic             timeout_o
);

  localparam int unsigned CW = BASE_EXP + (1 << PER_W) + 1;
  localparam int unsigned HW = $clog2(HOLD_CYC);

  wd_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [HW-1:0]   hcnt_q, hcnt_d;
  logic [CW-1:0]   lim_m1;
  logic            cnt_ce;
  logic            timeout;

  assign lim_m1 = (CW'(1) << (BASE_EXP + int'(per))) - CW'(1);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hcnt_d  = hcnt_q;
    timeout = 1'b0;
    if (por) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      hcnt_d = '0;
    end else if (st_q == ST_HOLD) begin
      cnt_d = '0;
      if (hcnt_q == HW'(HOLD_CYC - 1)) begin
        st_d   = ST_RUN;
        hcnt_d = '0;
      end else begin
        hcnt_d = hcnt_q + HW'(1);
      end
    end else if (!en || kick || src_clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= lim_m1) begin
        timeout = 1'b1;
        st_d    = ST_HOLD;
        cnt_d   = '0;
        hcnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  assign cnt_ce = (cnt_d != cnt_q) || (st_d != st_q) || (hcnt_d != hcnt_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      hcnt_q <= '0;
    end else if (cnt_ce) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign hold_o    = (st_q == ST_HOLD);
  assign timeout_o = timeout;

  // R10: a disabled watchdog never enters the hold state
  assert_off_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_RUN && !en) |=> st_q == ST_RUN);

  // R3: a restart strobe prevents a timeout in that cycle
  assert_kick_blocks_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_RUN && kick) |=> st_q == ST_RUN);

  // R4: a fresh hold lasts more than one cycle unless power-on intervenes
  assert_hold_min_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(hold_o) && !por) |=> hold_o);

endmodule

// File: rtl/wdt_flags.sv
module wdt_flags
  import wdt_rst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               por,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] keep,
  input  logic [NUM_SRC-1:0] set_vec,
  output logic [NUM_SRC-1:0] flags_o
);

  logic [NUM_SRC-1:0] flags_q, flags_d;
  logic [NUM_SRC-1:0] por_only;

  always_comb begin
    por_only          = '0;
    por_only[IDX_POR] = 1'b1;
  end

  always_comb begin
    if (por) begin
      flags_d = por_only;
    end else begin
      flags_d = (wr ? (flags_q & keep) : flags_q) | set_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flags_q <= por_only;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R8: power-on leaves only its own flag
  assert_por_flags_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    por |=> (flags_q == por_only));

  // R9: without a write or power-on no flag is lost
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr && !por) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/wdt_reset_unit.sv
module wdt_reset_unit
  import wdt_rst_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned WIN_CYC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               kick,
  input  logic               ctl_wr,
  input  logic               ctl_unlock,
  input  logic               ctl_en,
  input  logic [PER_W-1:0]   ctl_period,
  input  logic               flag_wr,
  input  logic [NUM_SRC-1:0] flag_keep,
  input  logic               por_req,
  input  logic               ext_req,
  input  logic               bod_req,
  input  logic               dbg_req,
  output logic               sys_rst_req,
  output logic [NUM_SRC-1:0] cause_flags,
  output logic               cfg_en,
  output logic [PER_W-1:0]   cfg_period
);

  logic [1:0]         rst_sync_q;
  logic               rst_sn;
  logic               en;
  logic [PER_W-1:0]   per;
  logic               hold;
  logic               timeout;
  logic               src_clr;
  logic [NUM_SRC-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sn  = rst_sync_q[1];
  assign src_clr = ext_req | bod_req | dbg_req;

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_EXT] = ext_req;
    set_vec[IDX_BOD] = bod_req;
    set_vec[IDX_WDT] = timeout;
    set_vec[IDX_DBG] = dbg_req;
  end

  wdt_ctl #(.WIN_CYC(WIN_CYC)) i_ctl (
    .clk    (clk),
    .rst_sn (rst_sn),
    .por    (por_req),
    .wr     (ctl_wr),
    .unlock (ctl_unlock),
    .en_in  (ctl_en),
    .per_in (ctl_period),
    .en_o   (en),
    .per_o  (per)
  );

  wdt_count #(.BASE_EXP(BASE_EXP), .HOLD_CYC(HOLD_CYC)) i_count (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .por       (por_req),
    .src_clr   (src_clr),
    .kick      (kick),
    .tick      (tick),
    .en        (en),
    .per       (per),
    .hold_o    (hold),
    .timeout_o (timeout)
  );

  wdt_flags i_flags (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .por     (por_req),
    .wr      (flag_wr),
    .keep    (flag_keep),
    .set_vec (set_vec),
    .flags_o (cause_flags)
  );

  assign sys_rst_req = hold;
  assign cfg_en      = en;
  assign cfg_period  = per;

  // R6: a rising reset request is always accompanied by the watchdog flag
  assert_wdt_flag_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sys_rst_req) |-> cause_flags[IDX_WDT]);

endmodule

// File: tb/test_wdt_reset_unit.sv
module test_wdt_reset_unit;

  localparam int CLK_PERIOD = 10;
  localparam int B          = 3;
  localparam int HOLD       = 16;
  localparam int WIN        = 4;

  logic       clk;
  logic       rst_n;
  logic       tick, kick, ctl_wr, ctl_unlock, ctl_en;
  logic [2:0] ctl_period;
  logic       flag_wr;
  logic [4:0] flag_keep;
  logic       por_req, ext_req, bod_req, dbg_req;
  logic       sys_rst_req;
  logic [4:0] cause_flags;
  logic       cfg_en;
  logic [2:0] cfg_period;

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference state
  int m_en, m_per, m_win, m_cnt, m_hold, m_flags;

  wdt_reset_unit #(.BASE_EXP(B), .HOLD_CYC(HOLD), .WIN_CYC(WIN)) i_wdt_reset_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .ctl_wr(ctl_wr), .ctl_unlock(ctl_unlock), .ctl_en(ctl_en), .ctl_period(ctl_period),
    .flag_wr(flag_wr), .flag_keep(flag_keep),
    .por_req(por_req), .ext_req(ext_req), .bod_req(bod_req), .dbg_req(dbg_req),
    .sys_rst_req(sys_rst_req), .cause_flags(cause_flags),
    .cfg_en(cfg_en), .cfg_period(cfg_period)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_win = 0; m_cnt = 0; m_hold = 0; m_flags = 1;
    end else begin
      int n_en, n_per, n_win, n_cnt, n_hold, n_flags, wset;
      n_en = m_en; n_per = m_per; n_win = m_win; n_cnt = m_cnt; n_hold = m_hold;
      wset = 0;
      if (por_req) begin
        n_en = 0; n_per = 0; n_win = 0;
      end else if (ctl_wr) begin
        if (ctl_unlock) begin
          n_win = WIN; n_en = m_en | ctl_en;
        end else if (m_win > 0) begin
          n_en = ctl_en; n_per = ctl_period; n_win = 0;
        end else begin
          n_en = m_en | ctl_en;
        end
      end else if (m_win > 0) begin
        n_win = m_win - 1;
      end
      if (por_req) begin
        n_hold = 0; n_cnt = 0;
      end else if (m_hold > 0) begin
        n_hold = m_hold - 1; n_cnt = 0;
      end else if (m_en == 0 || kick || ext_req || bod_req || dbg_req) begin
        n_cnt = 0;
      end else if (tick) begin
        if (m_cnt + 1 >= (1 << (B + m_per))) begin
          n_hold = HOLD; n_cnt = 0; wset = 1;
        end else begin
          n_cnt = m_cnt + 1;
        end
      end
      if (por_req) n_flags = 1;
      else begin
        n_flags = flag_wr ? (m_flags & flag_keep) : m_flags;
        n_flags = n_flags | (ext_req << 1) | (bod_req << 2) | (wset << 3) | (dbg_req << 4);
      end
      m_en = n_en; m_per = n_per; m_win = n_win; m_cnt = n_cnt;
      m_hold = n_hold; m_flags = n_flags;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act %0d exp %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    tick = 1'b1; kick = 1'b0; ctl_wr = 1'b0; ctl_unlock = 1'b0; ctl_en = 1'b0;
    ctl_period = 3'd0; flag_wr = 1'b0; flag_keep = 5'h1f;
    por_req = 1'b0; ext_req = 1'b0; bod_req = 1'b0; dbg_req = 1'b0;
  endtask

  // advance one cycle and compare every output with the reference model
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(sys_rst_req == (m_hold > 0), "R4 model request", int'(sys_rst_req), int'(m_hold > 0));
    check(int'(cause_flags) == m_flags, "R7 model flags", int'(cause_flags), m_flags);
    check(int'(cfg_en) == m_en, "R5 model enable", int'(cfg_en), m_en);
    check(int'(cfg_period) == m_per, "R5 model period", int'(cfg_period), m_per);
    idle();
  endtask

  task automatic ctl(input bit unl, input bit en, input int per);
    ctl_wr = 1'b1; ctl_unlock = unl; ctl_en = en; ctl_period = 3'(per);
    step();
  endtask

  task automatic wait_req(input int max, output int n);
    n = 0;
    while (!sys_rst_req && n < max) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act 1 exp 0");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check(cause_flags == 5'b00001, "R1 flags", int'(cause_flags), 1);
    check(cfg_en == 1'b0, "R1 enable", int'(cfg_en), 0);
    check(cfg_period == 3'd0, "R1 period", int'(cfg_period), 0);
    check(sys_rst_req == 1'b0, "R1 request", int'(sys_rst_req), 0);

    // R5 locked period write is ignored
    ctl(1'b0, 1'b0, 2);
    check(cfg_period == 3'd0, "R5 locked period", int'(cfg_period), 0);

    // R5 unlocked write sets period 1 and enables
    ctl(1'b1, 1'b0, 5);
    check(cfg_period == 3'd0, "R5 unlock write keeps period", int'(cfg_period), 0);
    ctl(1'b0, 1'b1, 1);
    check(cfg_period == 3'd1 && cfg_en, "R5 window write", int'(cfg_period), 1);

    // R2 timeout after 2^(B+1) ticks
    wait_req(200, n);
    check(n == 16, "R2 period 1 timeout cycles", n, 16);

    // R4 hold lasts 16 cycles even while kicked
    n = 0;
    while (sys_rst_req && n < 100) begin
      kick = 1'b1;
      step();
      n++;
    end
    check(n == 16, "R4 hold length", n, 16);
    check(cause_flags == 5'b01001, "R6 watchdog flag", int'(cause_flags), 9);

    // R3 periodic restart and idle ticks keep request low
    for (int i = 0; i < 100; i++) begin
      if (i % 10 == 0) kick = 1'b1;
      step();
    end
    check(sys_rst_req == 1'b0, "R3 kicked no timeout", int'(sys_rst_req), 0);
    for (int i = 0; i < 50; i++) begin
      tick = 1'b0;
      step();
    end
    check(sys_rst_req == 1'b0, "R3 no tick no timeout", int'(sys_rst_req), 0);

    // R5 late write after window closes is ignored
    kick = 1'b1; ctl(1'b1, 1'b0, 0);
    for (int i = 0; i < WIN; i++) begin
      kick = 1'b1;
      step();
    end
    kick = 1'b1; ctl(1'b0, 1'b0, 3);
    check(cfg_en == 1'b1, "R5 late disable ignored", int'(cfg_en), 1);
    check(cfg_period == 3'd1, "R5 late period ignored", int'(cfg_period), 1);

    // R10 proper disable then no request
    kick = 1'b1; ctl(1'b1, 1'b0, 0);
    kick = 1'b1; ctl(1'b0, 1'b0, 0);
    check(cfg_en == 1'b0, "R10 disabled", int'(cfg_en), 0);
    wait_req(200, n);
    check(n == 200, "R10 no request while disabled", n, 200);

    // R7 source flags
    ext_req = 1'b1; step();
    bod_req = 1'b1; step();
    dbg_req = 1'b1; step();
    check(cause_flags == 5'b11111, "R7 source flags", int'(cause_flags), 31);

    // R9 clear with same-cycle set, then full clear
    flag_wr = 1'b1; flag_keep = 5'b11101; ext_req = 1'b1; step();
    check(cause_flags == 5'b11111, "R9 set wins", int'(cause_flags), 31);
    flag_wr = 1'b1; flag_keep = 5'b01111; step();
    check(cause_flags == 5'b01111, "R9 selective clear", int'(cause_flags), 15);
    flag_wr = 1'b1; flag_keep = 5'b00000; step();
    check(cause_flags == 5'b00000, "R9 full clear", int'(cause_flags), 0);
    repeat (5) step();
    check(cause_flags == 5'b00000, "R9 stays clear", int'(cause_flags), 0);

    // R8 power-on during hold
    ctl(1'b0, 1'b1, 0);
    wait_req(100, n);
    check(n == 8, "R2 period 0 timeout cycles", n, 8);
    step();
    por_req = 1'b1; step();
    check(sys_rst_req == 1'b0, "R8 ends hold", int'(sys_rst_req), 0);
    check(cause_flags == 5'b00001, "R8 flags", int'(cause_flags), 1);
    check(cfg_en == 1'b0, "R8 disables", int'(cfg_en), 0);

    // mixed pseudo-random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      tick       = ($urandom % 4) != 0;
      kick       = ($urandom % 60) == 0;
      ctl_wr     = ($urandom % 12) == 0;
      ctl_unlock = ($urandom % 2) == 0;
      ctl_en     = ($urandom % 3) != 0;
      ctl_period = 3'($urandom % 3);
      flag_wr    = ($urandom % 40) == 0;
      flag_keep  = 5'($urandom);
      ext_req    = ($urandom % 300) == 0;
      bod_req    = ($urandom % 300) == 0;
      dbg_req    = ($urandom % 300) == 0;
      por_req    = ($urandom % 900) == 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule